// File: doc/BRIEF.md
# Posted CAS Additive Latency Scheduler

This block sits between the command front end of a DDR2 memory controller and the point where column commands are issued internally. The front end may hand over a READ or WRITE early, before the activate-to-column delay of the open row has run out. The block holds each such command for a programmed number of clocks, the additive latency, and then releases it. It releases commands in the order they arrived and can take one new command on every clock.

The additive latency arrives as a 3-bit field in binary, where codes 0 to 4 mean 0 to 4 clocks. The block also takes the CAS latency and the minimum activate-to-column delay in clocks. From these it reports the read latency and the write latency that the data path must use. Some settings are not allowed: a reserved code, or an additive latency longer than the activate-to-column delay. Either one raises a configuration-error flag. While that flag is high, incoming commands are dropped and nothing is issued.

Top module: `posted_cas_sched`

## Requirements
- R1: `al_code` is a binary count of clocks. Values 0, 1, 2, 3 and 4 select an additive latency of that many clocks.
- R2: Codes 5, 6 and 7 of `al_code` are reserved. Any of them drives `cfg_err` high in the same cycle.
- R3: `cfg_err` is high whenever `al_code` is greater than `trcd_min`. It stays low when `al_code` equals `trcd_min` and the code is 0 to 4.
- R4: While `cfg_err` is high, `iss_valid` is low. A command presented while `cfg_err` is high is dropped and is never issued, even after the configuration becomes legal again.
- R5: With an additive latency N of 1 to 4, a command sampled at a rising edge appears on `iss_valid` right after the Nth rising edge from that one, counting it as the first. `iss_valid` is low on the clocks in between.
- R6: With an additive latency of 0, the command shows on the issue outputs in the same cycle it is presented, with no register stage in the path.
- R7: `rd_lat` equals `al_code` plus `cas_lat`, computed at full width without wrap.
- R8: `wr_lat` equals `rd_lat` minus one. It saturates at 0 when `rd_lat` is 0.
- R9: Commands presented on consecutive clocks come out on consecutive clocks in their original order, one per clock.
- R10: The issued command keeps its direction (`iss_is_wr`: 1 = WRITE, 0 = READ) and its tag (`iss_tag`) unchanged.
- R11: After reset the delay pipeline is empty. `iss_valid` stays low until a command is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A READ or WRITE is presented this cycle |
| cmd_is_wr | input | 1 | 1 = WRITE, 0 = READ |
| cmd_tag | input | TAG_W | Bank/column tag carried with the command |
| al_code | input | 3 | Additive latency field |
| cas_lat | input | CL_W | CAS latency in clocks |
| trcd_min | input | TRCD_W | Minimum activate-to-column delay in clocks |
| iss_valid | output | 1 | Delayed command issued internally |
| iss_is_wr | output | 1 | Direction of the issued command |
| iss_tag | output | TAG_W | Tag of the issued command |
| rd_lat | output | LAT_W | Read latency (LAT_W = max(CL_W,3)+1) |
| wr_lat | output | LAT_W | Write latency |
| cfg_err | output | 1 | Configuration error, new commands blocked |

## Verification
The bench builds the block with its default parameters: 16-bit tags, a 4-bit CAS latency field and a 4-bit activate-to-column field. Every legal additive latency from 0 to the maximum of 4 is therefore reachable, as are all three reserved codes. The 4-bit fields also cover the widest sum of 4 + 15, so the full read latency width and the saturating write latency at zero can both be checked. Because each stage holds a distinct 16-bit tag, a burst shows right away if commands are reordered or lost inside the four-stage pipeline.

// File: rtl/pcas_pkg.sv
package pcas_pkg;
    // width of the additive latency field and its largest legal value
    localparam int AL_CODE_W = 3;
    localparam int AL_LIMIT  = 4;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/pcas_cfg_check.sv
module pcas_cfg_check
    import pcas_pkg::*;
#(
    parameter int TRCD_W = 4
) (
    input  logic [AL_CODE_W-1:0] al_code,
    input  logic [TRCD_W-1:0]    trcd_min,
    output logic                 err
);
    localparam int CMP_W = max_int(AL_CODE_W, TRCD_W) + 1;

    logic [CMP_W-1:0] al_ext;
    logic [CMP_W-1:0] trcd_ext;
    logic             reserved;
    logic             too_long;

    always_comb begin
        al_ext   = CMP_W'(al_code);
        trcd_ext = CMP_W'(trcd_min);
        reserved = (al_ext > CMP_W'(AL_LIMIT));
        too_long = (al_ext > trcd_ext);
        err      = reserved | too_long;
    end
endmodule

// File: rtl/pcas_lat_calc.sv
module pcas_lat_calc
    import pcas_pkg::*;
#(
    parameter int CL_W  = 4,
    parameter int LAT_W = 5
) (
    input  logic [AL_CODE_W-1:0] al_code,
    input  logic [CL_W-1:0]      cas_lat,
    output logic [LAT_W-1:0]     rd_lat,
    output logic [LAT_W-1:0]     wr_lat
);
    logic [LAT_W-1:0] sum;

    always_comb begin
        sum    = LAT_W'(al_code) + LAT_W'(cas_lat);
        rd_lat = sum;
        wr_lat = (sum == '0) ? '0 : sum - LAT_W'(1);
    end
endmodule

// File: rtl/pcas_delay_line.sv
module pcas_delay_line
    import pcas_pkg::*;
#(
    parameter int TAG_W = 16,
    parameter int DEPTH = AL_LIMIT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AL_CODE_W-1:0] sel,
    input  logic                 in_vld,
    input  logic                 in_wr,
    input  logic [TAG_W-1:0]     in_tag,
    output logic                 out_vld,
    output logic                 out_wr,
    output logic [TAG_W-1:0]     out_tag
);
    typedef struct packed {
        logic             vld;
        logic             wr;
        logic [TAG_W-1:0] tag;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] stg;
    } line_t;

    line_t line_d, line_q;
    ent_t  head;
    ent_t  tap;

    always_comb begin
        head.vld = in_vld;
        head.wr  = in_wr;
        head.tag = in_tag;
    end

    // next-state: stage 0 takes the new entry, each later stage the one before
    always_comb begin
        line_d        = line_q;
        line_d.stg[0] = head;
        for (int i = 1; i < DEPTH; i++) begin
            line_d.stg[i] = line_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    // tap select: zero latency bypasses every register
    always_comb begin
        tap = head;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(sel) == i + 1) tap = line_q.stg[i];
        end
    end

    generate
        if (DEPTH > 0) begin : g_out
            always_comb begin
                out_vld = tap.vld;
                out_wr  = tap.wr;
                out_tag = tap.tag;
            end
        end
    endgenerate
endmodule

// File: rtl/posted_cas_sched.sv
module posted_cas_sched
    import pcas_pkg::*;
#(
    parameter int TAG_W  = 16,
    parameter int CL_W   = 4,
    parameter int TRCD_W = 4,
    parameter int LAT_W  = max_int(CL_W, AL_CODE_W) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic                 cmd_is_wr,
    input  logic [TAG_W-1:0]     cmd_tag,
    input  logic [AL_CODE_W-1:0] al_code,
    input  logic [CL_W-1:0]      cas_lat,
    input  logic [TRCD_W-1:0]    trcd_min,
    output logic                 iss_valid,
    output logic                 iss_is_wr,
    output logic [TAG_W-1:0]     iss_tag,
    output logic [LAT_W-1:0]     rd_lat,
    output logic [LAT_W-1:0]     wr_lat,
    output logic                 cfg_err
);
    logic             err;
    logic             accept;
    logic             dl_vld;
    logic             dl_wr;
    logic [TAG_W-1:0] dl_tag;

    pcas_cfg_check #(.TRCD_W(TRCD_W)) u_cfg (
        .al_code  (al_code),
        .trcd_min (trcd_min),
        .err      (err)
    );

    pcas_lat_calc #(.CL_W(CL_W), .LAT_W(LAT_W)) u_lat (
        .al_code (al_code),
        .cas_lat (cas_lat),
        .rd_lat  (rd_lat),
        .wr_lat  (wr_lat)
    );

    always_comb accept = cmd_valid & ~err;

    pcas_delay_line #(.TAG_W(TAG_W), .DEPTH(AL_LIMIT)) u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (al_code),
        .in_vld  (accept),
        .in_wr   (cmd_is_wr),
        .in_tag  (cmd_tag),
        .out_vld (dl_vld),
        .out_wr  (dl_wr),
        .out_tag (dl_tag)
    );

    always_comb begin
        iss_valid = dl_vld & ~err;
        iss_is_wr = dl_wr;
        iss_tag   = dl_tag;
        cfg_err   = err;
    end
endmodule

// File: rtl/pcas_sched_chk.sv
module pcas_sched_chk
    import pcas_pkg::*;
#(
    parameter int TAG_W  = 16,
    parameter int CL_W   = 4,
    parameter int TRCD_W = 4,
    parameter int LAT_W  = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic                 cmd_is_wr,
    input logic [TAG_W-1:0]     cmd_tag,
    input logic [AL_CODE_W-1:0] al_code,
    input logic [CL_W-1:0]      cas_lat,
    input logic [TRCD_W-1:0]    trcd_min,
    input logic                 iss_valid,
    input logic                 iss_is_wr,
    input logic [TAG_W-1:0]     iss_tag,
    input logic [LAT_W-1:0]     rd_lat,
    input logic [LAT_W-1:0]     wr_lat,
    input logic                 cfg_err
);
    // R4
    no_issue_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !iss_valid);

    // R2
    reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (al_code > 3'd4) |-> cfg_err);

    // R6
    zero_al_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (al_code == 3'd0 && !cfg_err && cmd_valid)
            |-> (iss_valid && iss_tag == cmd_tag && iss_is_wr == cmd_is_wr));

    // R5
    one_clk_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cmd_valid) && $past(al_code) == 3'd1
         && al_code == 3'd1 && !$past(cfg_err) && !cfg_err)
            |-> (iss_valid && iss_tag == $past(cmd_tag)));

    // R7
    rd_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lat == LAT_W'(al_code) + LAT_W'(cas_lat));

    // R8
    wr_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lat != '0) |-> (wr_lat + LAT_W'(1) == rd_lat));
endmodule

bind posted_cas_sched pcas_sched_chk #(
    .TAG_W(TAG_W), .CL_W(CL_W), .TRCD_W(TRCD_W), .LAT_W(LAT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_wr(cmd_is_wr),
    .cmd_tag(cmd_tag), .al_code(al_code), .cas_lat(cas_lat), .trcd_min(trcd_min),
    .iss_valid(iss_valid), .iss_is_wr(iss_is_wr), .iss_tag(iss_tag),
    .rd_lat(rd_lat), .wr_lat(wr_lat), .cfg_err(cfg_err)
);

// File: tb/sim_posted_cas_sched.sv
module sim_posted_cas_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_is_wr = 1'b0;
    logic [15:0] cmd_tag = '0;
    logic [2:0]  al_code = '0;
    logic [3:0]  cas_lat = 4'd3;
    logic [3:0]  trcd_min = 4'd4;
    logic        iss_valid, iss_is_wr, cfg_err;
    logic [15:0] iss_tag;
    logic [4:0]  rd_lat, wr_lat;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    posted_cas_sched u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_wr(cmd_is_wr),
        .cmd_tag(cmd_tag), .al_code(al_code), .cas_lat(cas_lat), .trcd_min(trcd_min),
        .iss_valid(iss_valid), .iss_is_wr(iss_is_wr), .iss_tag(iss_tag),
        .rd_lat(rd_lat), .wr_lat(wr_lat), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(iss_valid == 1'b0, "R11 valid in reset", iss_valid, 0);
        chk(cfg_err == 1'b0, "R11 err in reset", cfg_err, 0);
        @(negedge clk); rst_n = 1'b1;
        idle(3);
        chk(iss_valid == 1'b0, "R11 empty after reset", iss_valid, 0);
    endtask

    // one command, exact latency: R1 R5 R6 R10
    task automatic t_single(input logic [2:0] al, input logic wr, input logic [15:0] tag);
        al_code = al; trcd_min = 4'd4;
        idle(6);
        cmd_valid = 1'b1; cmd_is_wr = wr; cmd_tag = tag;
        if (al == 0) begin
            #1;
            chk(iss_valid == 1'b1, "R6 same-cycle valid", iss_valid, 1);
            chk(iss_tag == tag && iss_is_wr == wr, "R10 tag/dir al0", iss_tag, tag);
            @(negedge clk); cmd_valid = 1'b0; #1;
            chk(iss_valid == 1'b0, "R6 gone after drop", iss_valid, 0);
        end else begin
            for (int i = 1; i <= al; i++) begin
                @(negedge clk);
                if (i == 1) cmd_valid = 1'b0;
                if (i < al) chk(iss_valid == 1'b0, "R5 early issue", iss_valid, 0);
                else begin
                    chk(iss_valid == 1'b1, "R1 R5 issue at latency", iss_valid, 1);
                    chk(iss_tag == tag && iss_is_wr == wr, "R10 tag/dir", iss_tag, tag);
                end
            end
            @(negedge clk);
            chk(iss_valid == 1'b0, "R5 single issue", iss_valid, 0);
        end
    endtask

    // back-to-back burst: R9
    task automatic t_burst;
        al_code = 3'd3; trcd_min = 4'd4;
        idle(6);
        for (int j = 0; j < 8; j++) begin
            if (j >= 3 && j <= 6) begin
                chk(iss_valid == 1'b1, "R9 burst valid", iss_valid, 1);
                chk(iss_tag == 16'hB000 + 16'(j - 3), "R9 burst order", iss_tag, 16'hB000 + j - 3);
                chk(iss_is_wr == ((j - 3) % 2 == 1), "R10 burst dir", iss_is_wr, (j - 3) % 2);
            end else begin
                chk(iss_valid == 1'b0, "R9 burst gap", iss_valid, 0);
            end
            cmd_valid = (j < 4);
            cmd_tag   = 16'hB000 + 16'(j);
            cmd_is_wr = (j % 2 == 1);
            @(negedge clk);
        end
        cmd_valid = 1'b0;
    endtask

    // error handling: R2 R3 R4
    task automatic t_errors;
        trcd_min = 4'd7;
        for (int c = 5; c < 8; c++) begin
            al_code = 3'(c); #1;
            chk(cfg_err == 1'b1, "R2 reserved code", cfg_err, 1);
        end
        al_code = 3'd3; trcd_min = 4'd2; #1;
        chk(cfg_err == 1'b1, "R3 al over trcd", cfg_err, 1);
        al_code = 3'd2; #1;
        chk(cfg_err == 1'b0, "R3 al equal trcd", cfg_err, 0);
        // present a command under an error, then go legal
        idle(5);
        al_code = 3'd3; trcd_min = 4'd1;
        cmd_valid = 1'b1; cmd_tag = 16'hDEAD; #1;
        chk(iss_valid == 1'b0, "R4 no issue under error", iss_valid, 0);
        @(negedge clk); cmd_valid = 1'b0;
        al_code = 3'd1; trcd_min = 4'd4;
        for (int i = 0; i < 5; i++) begin
            #1;
            chk(iss_valid == 1'b0, "R4 dropped command", iss_valid, 0);
            al_code = 3'(i % 5);
            @(negedge clk);
        end
        // in-flight entry masked while error is raised
        al_code = 3'd2; trcd_min = 4'd4; idle(3);
        cmd_valid = 1'b1; cmd_tag = 16'h0042;
        @(negedge clk); cmd_valid = 1'b0; al_code = 3'd6; #1;
        chk(iss_valid == 1'b0, "R4 masked during error", iss_valid, 0);
        al_code = 3'd2;
    endtask

    // latency outputs: R7 R8
    task automatic t_lat(input logic [2:0] al, input logic [3:0] cl);
        al_code = al; cas_lat = cl; trcd_min = 4'd15; #1;
        chk(rd_lat == 5'(al) + 5'(cl), "R7 read latency", rd_lat, al + cl);
        chk(wr_lat == ((al + cl == 0) ? 5'd0 : 5'(al + cl - 1)), "R8 write latency",
            wr_lat, (al + cl == 0) ? 0 : al + cl - 1);
    endtask

    initial begin
        t_reset();
        t_single(3'd0, 1'b0, 16'h1111);
        t_single(3'd1, 1'b1, 16'h2222);
        t_single(3'd2, 1'b0, 16'h3333);
        t_single(3'd3, 1'b1, 16'h4444);
        t_single(3'd4, 1'b0, 16'h5555);
        t_burst();
        t_errors();
        t_lat(3'd4, 4'd5);
        t_lat(3'd0, 4'd0);
        t_lat(3'd0, 4'd3);
        t_lat(3'd4, 4'd15);
        t_lat(3'd2, 4'd1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule